// File: doc/BRIEF.md
# Page Program Data Buffer

This block collects the data stage of a serial-flash page-program operation and turns it into a sequence of byte writes into the storage array. A command decoder tells it where the operation starts. From that start address it keeps the page number (the address bits above the in-page offset) and an in-page write pointer. Each complete data byte is placed at the pointer, and the pointer then moves forward and wraps around inside the page. A byte that lands on an offset already filled replaces the earlier one, so when more than one page of data arrives only the last page-worth of bytes is kept. A mask records which offsets received data.

When chip select is released on a byte boundary, the enable from the status controller is high and at least one byte is held, the block walks the marked offsets from lowest to highest. It issues one array write per clock. Each written value is the current array byte ANDed with the new byte, because programming can only clear bits. Offsets that received no byte are never written. A single-cycle completion pulse follows the last write. A release with a partial byte, with the enable low, or with no data discards the operation with no write and no pulse. Protection decisions and the busy timer are handled outside this block.

Top module: `pp_page_buffer`

## Requirements
- R1: After reset, `mem_we` and `commit_done` are low, and no write occurs until an operation is committed.
- R2: Every write of a commit targets the page given by `cmd_addr[ADDR_W-1:log2(PAGE_BYTES)]` of the accepted start. The first data byte goes to offset `cmd_addr[log2(PAGE_BYTES)-1:0]`.
- R3: Each accepted data byte goes to the offset after the previous one. After offset PAGE_BYTES-1 the next byte goes to offset 0 of the same page.
- R4: When more than PAGE_BYTES bytes arrive, a later byte at an offset replaces the earlier one, so the last PAGE_BYTES bytes are the ones committed.
- R5: Offsets of the page that received no data byte get no write strobe, and their array contents stay unchanged.
- R6: Each written value equals `mem_rdata & new_byte`, where `mem_rdata` is the array byte at `mem_addr` in the same cycle.
- R7: A commit writes the filled offsets in strictly ascending order, one per clock in consecutive cycles. The first write appears in the cycle after the clock edge that samples `cs_release`.
- R8: `commit_done` is high for exactly one cycle, the cycle right after the last write of a commit.
- R9: A release with `cs_partial` high causes no write and no `commit_done`.
- R10: A release with `prog_enable` low causes no write and no `commit_done`.
- R11: A release after a start with no data byte causes no write and no `commit_done`.
- R12: Data bytes that arrive while no operation is open (before any start, or after a release) are ignored.
- R13: A `cmd_start` that arrives while a commit is writing is ignored, and the commit continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start of a program operation; `cmd_addr` is valid |
| cmd_addr | input | ADDR_W | Start address (page number and offset) |
| rx_byte_vld | input | 1 | A complete data byte is present on `rx_byte` |
| rx_byte | input | 8 | Received data byte |
| cs_release | input | 1 | Chip select was released this cycle |
| cs_partial | input | 1 | With `cs_release`: the last byte was incomplete |
| prog_enable | input | 1 | Permission from the status controller, sampled with `cs_release` |
| mem_rdata | input | 8 | Array byte at `mem_addr`, read combinationally |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array address of the read and the write |
| mem_wdata | output | 8 | Value to store (old AND new) |
| commit_done | output | 1 | One-cycle pulse after the last write of a commit |

## Verification
The bench builds the block with PAGE_BYTES=16 and ADDR_W=10, and models a 1 KiB array. With these values, in-page wrap and overflow past a full page take only a few dozen bytes to reach. Every offset order, including a commit that fills the whole page, runs in a few cycles. The small address space also allows the whole array to be compared after each scenario, which shows that unsent offsets and other pages stay untouched.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int DEF_PAGE_BYTES = 256;
    localparam int DEF_ADDR_W     = 24;
    localparam int BYTE_W         = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Chip-select release event, grouped as seen by the commit gate.
    typedef struct packed {
        logic rise;
        logic partial;
        logic enable;
    } cs_event_t;

    typedef enum logic {
        CM_IDLE = 1'b0,
        CM_RUN  = 1'b1
    } commit_state_e;

endpackage

// File: rtl/pp_collect.sv
module pp_collect
    import pp_pkg::*;
#(
    parameter int PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int ADDR_W     = DEF_ADDR_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start_i,
    input  logic [ADDR_W-1:0]                      start_addr_i,
    input  logic                                   byte_vld_i,
    input  byte_t                                  byte_i,
    input  logic                                   close_i,
    input  logic [$clog2(PAGE_BYTES)-1:0]          rd_off_i,
    output byte_t                                  rd_byte_o,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   base_o,
    output logic [PAGE_BYTES-1:0]                  vmask_o,
    output logic                                   has_data_o,
    output logic                                   open_o
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;

    logic                  open_q;
    logic [OFS_W-1:0]      ptr_q;
    logic [BASE_W-1:0]     base_q;
    logic [PAGE_BYTES-1:0] vmask_q;
    byte_t                 store_q [PAGE_BYTES];

    logic take;
    assign take = open_q & byte_vld_i & ~start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            ptr_q   <= '0;
            base_q  <= '0;
            vmask_q <= '0;
        end else if (start_i) begin
            open_q  <= 1'b1;
            ptr_q   <= start_addr_i[OFS_W-1:0];
            base_q  <= start_addr_i[ADDR_W-1:OFS_W];
            vmask_q <= '0;
        end else begin
            if (take) begin
                vmask_q[ptr_q] <= 1'b1;
                ptr_q          <= ptr_q + 1'b1;
            end
            if (close_i) begin
                open_q <= 1'b0;
            end
        end
    end

    // Data storage carries no reset: the valid mask qualifies every entry.
    always_ff @(posedge clk) begin
        if (take) begin
            store_q[ptr_q] <= byte_i;
        end
    end

    assign rd_byte_o  = store_q[rd_off_i];
    assign base_o     = base_q;
    assign vmask_o    = vmask_q;
    assign has_data_o = (|vmask_q) | take;
    assign open_o     = open_q;

    // R3: an accepted byte marks the slot the pointer held.
    assert_byte_marks_slot_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> vmask_q[$past(ptr_q)]);

    // R12: with no operation open and no new start, the mask cannot change.
    assert_closed_ignores_R12: assert property (@(posedge clk) disable iff (rst)
        (!open_q && !start_i) |=> $stable(vmask_q));

endmodule

// File: rtl/pp_commit.sv
module pp_commit
    import pp_pkg::*;
#(
    parameter int PAGE_BYTES = DEF_PAGE_BYTES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          go_i,
    input  logic [PAGE_BYTES-1:0]         vmask_i,
    output logic                          busy_o,
    output logic [$clog2(PAGE_BYTES)-1:0] sel_off_o,
    output logic                          done_o
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    commit_state_e         state_q;
    logic                  done_q;
    logic [PAGE_BYTES-1:0] wrote_q;
    logic [PAGE_BYTES-1:0] left;
    logic [PAGE_BYTES-1:0] rest;
    logic [OFS_W-1:0]      sel;
    logic                  last;

    function automatic logic [OFS_W-1:0] first_set(input logic [PAGE_BYTES-1:0] v);
        logic [OFS_W-1:0] idx;
        idx = '0;
        for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
            if (v[i]) idx = OFS_W'(i);
        end
        return idx;
    endfunction

    always_comb begin
        left = vmask_i & ~wrote_q;
        rest = left & (left - 1'b1);
        sel  = first_set(left);
        last = (rest == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CM_IDLE;
            done_q  <= 1'b0;
            wrote_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CM_IDLE: begin
                    if (go_i) begin
                        state_q <= CM_RUN;
                        wrote_q <= '0;
                    end
                end
                CM_RUN: begin
                    wrote_q[sel] <= 1'b1;
                    if (last) begin
                        state_q <= CM_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= CM_IDLE;
            endcase
        end
    end

    assign busy_o    = (state_q == CM_RUN);
    assign sel_off_o = sel;
    assign done_o    = done_q;

    // R7: offsets of one commit strictly increase from write to write.
    assert_ascending_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (sel > $past(sel)));

    // R5: a write is only issued while some filled offset is still pending.
    assert_write_has_target_R5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (left != '0));

    // R8: the completion pulse comes right after the run ends.
    assert_done_after_run_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

endmodule

// File: rtl/pp_page_buffer.sv
module pp_page_buffer
    import pp_pkg::*;
#(
    parameter int PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int ADDR_W     = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              cs_release,
    input  logic              cs_partial,
    input  logic              prog_enable,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              commit_done
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;

    cs_event_t             cs_ev;
    logic                  busy;
    logic                  start_ok;
    logic                  go;
    logic                  open;
    logic                  has_data;
    logic [OFS_W-1:0]      sel_off;
    byte_t                 new_byte;
    logic [BASE_W-1:0]     base;
    logic [PAGE_BYTES-1:0] vmask;

    assign cs_ev    = '{rise: cs_release, partial: cs_partial, enable: prog_enable};
    assign start_ok = cmd_start & ~busy;
    assign go       = cs_ev.rise & ~cs_ev.partial & cs_ev.enable & open & has_data;

    pp_collect #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_collect (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_ok),
        .start_addr_i (cmd_addr),
        .byte_vld_i   (rx_byte_vld),
        .byte_i       (rx_byte),
        .close_i      (cs_ev.rise),
        .rd_off_i     (sel_off),
        .rd_byte_o    (new_byte),
        .base_o       (base),
        .vmask_o      (vmask),
        .has_data_o   (has_data),
        .open_o       (open)
    );

    pp_commit #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_commit (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .vmask_i   (vmask),
        .busy_o    (busy),
        .sel_off_o (sel_off),
        .done_o    (commit_done)
    );

    assign mem_we    = busy;
    assign mem_addr  = {base, sel_off};
    assign mem_wdata = mem_rdata & new_byte;

    // R2: all writes of one commit stay inside a single page.
    assert_same_page_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])));

    // R9: a release on a partial byte starts no write.
    assert_partial_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (cs_release && cs_partial && !mem_we) |=> !mem_we);

    // R10: a release without permission starts no write.
    assert_disabled_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        (cs_release && !prog_enable && !mem_we) |=> !mem_we);

    // R6: a write never sets a bit that the array byte has clear.
    assert_only_clears_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_wdata & ~mem_rdata) == 8'h00));

endmodule

// File: tb/pp_page_buffer_tb.sv
module pp_page_buffer_tb;
    localparam int PB   = 16;
    localparam int AW   = 10;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          rx_byte_vld = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          cs_release = 1'b0;
    logic          cs_partial = 1'b0;
    logic          prog_enable = 1'b1;
    logic [7:0]    mem_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          commit_done;

    always #5 clk = ~clk;

    pp_page_buffer #(.PAGE_BYTES(PB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .cs_release(cs_release),
        .cs_partial(cs_partial), .prog_enable(prog_enable), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .commit_done(commit_done)
    );

    // Array seen by the design, and the reference copy.
    logic [7:0] dmem [MEMN];
    logic [7:0] rmem [MEMN];
    assign mem_rdata = dmem[mem_addr];
    always @(posedge clk) if (mem_we === 1'b1) dmem[mem_addr] <= mem_wdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit run_chk = 0;
    string tag = "R1";

    // Reference model state.
    bit         m_open = 0;
    int         m_base = 0;
    int         m_ptr = 0;
    logic [7:0] m_nb [PB];
    bit         m_nv [PB];
    int         q_addr [$];
    logic [7:0] q_data [$];
    bit         exp_done = 0;
    bit         shown_write = 0;

    // Per-clock comparison, sampled 3 ns after each rising edge.
    always @(posedge clk) begin
        #3;
        if (run_chk && !rst) begin
            checks++;
            if (q_addr.size() > 0) begin
                int a;
                logic [7:0] d;
                a = q_addr.pop_front();
                d = q_data.pop_front();
                shown_write = 1;
                if (!(mem_we === 1'b1 && int'(mem_addr) == a && mem_wdata === d && commit_done === 1'b0)) begin
                    failures++;
                    $display("FAIL %s: we=%b addr=%h data=%h done=%b, expected we=1 addr=%h data=%h done=0",
                             tag, mem_we, mem_addr, mem_wdata, commit_done, a, d);
                end
                if (q_addr.size() == 0) exp_done = 1;
            end else begin
                shown_write = 0;
                if (!(mem_we === 1'b0 && commit_done === exp_done)) begin
                    failures++;
                    $display("FAIL %s: we=%b done=%b, expected we=0 done=%b",
                             tag, mem_we, commit_done, exp_done);
                end
                exp_done = 0;
            end
        end
    end

    task automatic do_start(input int addr);
        cmd_start = 1'b1;
        cmd_addr  = AW'(addr);
        if (!(q_addr.size() > 0 || shown_write)) begin
            m_open = 1;
            m_base = addr / PB;
            m_ptr  = addr % PB;
            for (int i = 0; i < PB; i++) m_nv[i] = 0;
        end
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        rx_byte_vld = 1'b1;
        rx_byte     = d;
        if (m_open) begin
            m_nb[m_ptr] = d;
            m_nv[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % PB;
        end
        @(negedge clk);
        rx_byte_vld = 1'b0;
    endtask

    task automatic release_cs(input bit partial, input bit en);
        bit any;
        cs_release  = 1'b1;
        cs_partial  = partial;
        prog_enable = en;
        any = 0;
        for (int i = 0; i < PB; i++) if (m_nv[i]) any = 1;
        if (m_open && !partial && en && any) begin
            for (int o = 0; o < PB; o++) begin
                if (m_nv[o]) begin
                    int a;
                    a = m_base * PB + o;
                    rmem[a] = rmem[a] & m_nb[o];
                    q_addr.push_back(a);
                    q_data.push_back(rmem[a]);
                end
            end
        end
        m_open = 0;
        @(negedge clk);
        cs_release  = 1'b0;
        cs_partial  = 1'b0;
        prog_enable = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mem_check(input string t);
        int bad;
        bad = -1;
        for (int i = 0; i < MEMN; i++) if (bad < 0 && dmem[i] !== rmem[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s: array[%h]=%h, expected %h", t, bad, dmem[bad], rmem[bad]);
        end
    endtask

    initial begin
        for (int i = 0; i < MEMN; i++) begin
            logic [7:0] v;
            v = (i < 512) ? 8'((i * 37 + 11) | 8'h81) : 8'hFF;
            dmem[i] = v;
            rmem[i] = v;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_chk = 1;
        // R1: reset state at the ports.
        checks++;
        if (mem_we !== 1'b0 || commit_done !== 1'b0) begin
            failures++;
            $display("FAIL R1: we=%b done=%b, expected 0 0", mem_we, commit_done);
        end
        idle(2);

        tag = "R2 R6 R7 R8";
        do_start(12'h125);
        send(8'hA5); send(8'h3C); send(8'hF0); send(8'h0F);
        release_cs(0, 1);
        idle(8);
        mem_check("R2 R5 R6");

        tag = "R3 R7";
        do_start(12'h1AE);
        for (int i = 0; i < 5; i++) send(8'(8'hE7 - i * 17));
        release_cs(0, 1);
        idle(10);
        mem_check("R3 R5");

        tag = "R4 R7 R8";
        do_start(12'h203);
        for (int i = 0; i < 20; i++) send(8'(i * 13 + 7));
        release_cs(0, 1);
        idle(22);
        mem_check("R4");

        tag = "R9";
        do_start(12'h300);
        send(8'h00); send(8'h11);
        release_cs(1, 1);
        idle(5);
        mem_check("R9");

        tag = "R10";
        do_start(12'h310);
        send(8'h00); send(8'h22);
        release_cs(0, 0);
        idle(5);
        mem_check("R10");

        tag = "R11";
        do_start(12'h320);
        release_cs(0, 1);
        idle(5);
        mem_check("R11");

        tag = "R12";
        send(8'h00); send(8'h00); send(8'h00);
        do_start(12'h050);
        send(8'h5A);
        release_cs(0, 1);
        send(8'h00); send(8'h00);
        idle(5);
        mem_check("R12");

        tag = "R13 R7";
        do_start(12'h380);
        for (int i = 0; i < 10; i++) send(8'(8'hF3 ^ (i * 5)));
        release_cs(0, 1);
        idle(3);
        do_start(12'h000);
        send(8'h00); send(8'h00);
        release_cs(0, 1);
        idle(15);
        mem_check("R13");

        tag = "R3 R4 R8";
        do_start(12'h0F0);
        for (int i = 0; i < PB; i++) send(8'(8'hFE - i));
        release_cs(0, 1);
        idle(20);
        mem_check("R3 R4");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1: watchdog expired, actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule